// File: doc/BRIEF.md
# Configurable Logic Cell with Octet Configuration

This block is one programmable logic cell. Its function comes from a small set of 8-bit configuration octets. Each octet is loaded through a write port that carries an 8-bit selector and an 8-bit value. The datapath has these parts:

- Two 3-input lookup tables (X and Y), each holding its truth table in complemented form.
- A selector for the third table input.
- An AND of the W and Z inputs.
- A selector for the register input.
- One flip-flop whose asynchronous initialisation value can be configured.
- A centre output and a feedback line. Each one either shows the register or bypasses it.
- Two neighbour outputs, XO and YO. Each shows the centre output or its own table output.

The cell's four logic inputs, the clock enable and the asynchronous initialise input are ports of the block. When the block is integrated, a configuration loader writes the octets, and the neighbouring routing then uses the two neighbour outputs and the feedback line.

A configuration reset fills every octet with ones. In that state both tables produce constant zero, and both neighbour outputs follow the Z input through the bypass path.

Top module: `lcell_top`

## Requirements
- R1: While `rst_n` is low, every configuration octet is 0xFF and the register is 0. With that configuration, `out_xo`, `out_yo`, `out_c` and `out_fb` all equal `cell_z`.
- R2: An octet is written at a rising clock edge only when all of these hold: `cfg_we` is high, `cfg_z[7:4]` is 0000, and `cfg_z[3:0]` is 0001 (control), 0110 (X table), 0111 (Y table) or 1010 (initialise polarity). Any other write leaves every octet unchanged. A written value affects the outputs from the cycle after the edge.
- R3: The table index is {selected third input, `cell_y`, `cell_x`}, with `cell_x` in bit 0. Each table output is the complement of the stored bit at that index.
- R4: Control octet bit 5 selects `cell_w & cell_z` as the third table input. Otherwise bit 4 selects the register output. Otherwise `cell_w` is used. Bit 5 wins when both bits are set.
- R5: Control bit 7 selects `cell_z` as the register input. Otherwise bit 6 selects the Y table output. Otherwise the X table output is used. Bit 7 wins when both bits are set.
- R6: At a rising clock edge with `reg_ce` high and `reg_sr` low, the register loads the selected register input. With `reg_ce` low, the register holds its value.
- R7: While `reg_sr` is high, the register is forced at once and ahead of the clock. It takes 1 when bit 3 of the polarity octet is 0 (set), and 0 when that bit is 1 (reset).
- R8: Control bit 3 makes `out_c` equal the register input, and control bit 2 does the same for `out_fb`. When a bit is clear, its output shows the register.
- R9: Control bit 1 makes `out_xo` equal `out_c`, otherwise the X table output. Control bit 0 makes `out_yo` equal `out_c`, otherwise the Y table output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration octets and the cell register |
| rst_n | input | 1 | Active-low asynchronous configuration reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_z | input | 8 | Octet selector; upper nibble must be zero for cell octets |
| cfg_d | input | 8 | Octet value to write |
| cell_x | input | 1 | Cell input X, table index bit 0 |
| cell_y | input | 1 | Cell input Y, table index bit 1 |
| cell_w | input | 1 | Cell input W, default third table input |
| cell_z | input | 1 | Cell input Z, register-input source and AND operand |
| reg_ce | input | 1 | Register clock enable |
| reg_sr | input | 1 | Asynchronous initialise, active high |
| out_xo | output | 1 | Neighbour output X |
| out_yo | output | 1 | Neighbour output Y |
| out_c | output | 1 | Centre output |
| out_fb | output | 1 | Feedback line |

## Verification
The outputs follow changes on the logic inputs within the same cycle. The bench therefore drives inputs at the falling edge and compares one time unit later, in the same low phase. An octet write and a register load both take effect at the next rising edge. The reference model applies both after that edge, and the comparison in the following low phase picks them up. `reg_sr` acts without waiting for a clock edge, so the model forces its register as soon as it sees `reg_sr` high, before the comparison in that same low phase.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    localparam int OCT_W    = 8;
    localparam int ZADDR_W  = 8;
    localparam int ZSEL_W   = 4;
    localparam int NUM_OCT  = 4;
    localparam int LUT_IN   = 3;

    localparam int IDX_CTL  = 0;
    localparam int IDX_XLUT = 1;
    localparam int IDX_YLUT = 2;
    localparam int IDX_INIT = 3;
    localparam int INIT_BIT = 3;

    // control octet, most significant field first
    typedef struct packed {
        logic zm_r;
        logic yl_r;
        logic wz_wm;
        logic fb_wm;
        logic zm_c;
        logic zm_fb;
        logic c_xo;
        logic c_yo;
    } ctl_t;

    function automatic logic [ZSEL_W-1:0] oct_sel(input int idx);
        case (idx)
            IDX_CTL:  return 4'b0001;
            IDX_XLUT: return 4'b0110;
            IDX_YLUT: return 4'b0111;
            default:  return 4'b1010;
        endcase
    endfunction
endpackage

// File: rtl/lcell_cfg_file.sv
module lcell_cfg_file
    import lcell_pkg::*;
#(
    parameter int OW = OCT_W,
    parameter int AW = ZADDR_W,
    parameter int SW = ZSEL_W,
    parameter int NO = NUM_OCT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         zsel,
    input  logic [OW-1:0]         wdata,
    output logic [NO-1:0][OW-1:0] octs
);
    localparam int HI_W = AW - SW;

    logic hi_zero;
    assign hi_zero = (zsel[AW-1:SW] == {HI_W{1'b0}});

    for (genvar g = 0; g < NO; g++) begin : g_oct
        localparam logic [SW-1:0] SEL = SW'(oct_sel(g));
        logic hit;
        assign hit = we && hi_zero && (zsel[SW-1:0] == SEL);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                octs[g] <= {OW{1'b1}};
            else if (hit)
                octs[g] <= wdata;
        end
    end
endmodule

// File: rtl/lcell_lut3.sv
module lcell_lut3
    import lcell_pkg::*;
#(
    parameter int IN_W = LUT_IN
) (
    input  logic [(1<<IN_W)-1:0] tbl_n,
    input  logic [IN_W-1:0]      idx,
    output logic                 f
);
    // the stored table is complemented
    assign f = ~tbl_n[idx];
endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic sr,
    input  logic init_is_reset,
    input  logic ce,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n or posedge sr) begin
        if (!rst_n)
            q <= 1'b0;
        else if (sr)
            q <= ~init_is_reset;
        else if (ce)
            q <= d;
    end
endmodule

// File: rtl/lcell_top.sv
module lcell_top
    import lcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_z,
    input  logic [7:0] cfg_d,
    input  logic       cell_x,
    input  logic       cell_y,
    input  logic       cell_w,
    input  logic       cell_z,
    input  logic       reg_ce,
    input  logic       reg_sr,
    output logic       out_xo,
    output logic       out_yo,
    output logic       out_c,
    output logic       out_fb
);
    localparam int NLUT = 2;

    logic [NUM_OCT-1:0][OCT_W-1:0] oct;
    ctl_t                          ctl;
    logic                          ia, wm, rin, q_r;
    logic [LUT_IN-1:0]             lut_idx;
    logic [NLUT-1:0]               lut_f;
    logic                          xl, yl;
    logic                          unused_init;

    lcell_cfg_file u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .zsel  (cfg_z),
        .wdata (cfg_d),
        .octs  (oct)
    );

    assign ctl         = ctl_t'(oct[IDX_CTL]);
    assign unused_init = ^{oct[IDX_INIT][OCT_W-1:INIT_BIT+1], oct[IDX_INIT][INIT_BIT-1:0]};

    // third-input selector; feedback taken from the register output
    assign ia = cell_w & cell_z;
    always_comb begin
        if (ctl.wz_wm)      wm = ia;
        else if (ctl.fb_wm) wm = q_r;
        else                wm = cell_w;
    end

    assign lut_idx = {wm, cell_y, cell_x};

    for (genvar g = 0; g < NLUT; g++) begin : g_lut
        lcell_lut3 u_lut (
            .tbl_n (oct[IDX_XLUT + g]),
            .idx   (lut_idx),
            .f     (lut_f[g])
        );
    end
    assign xl = lut_f[0];
    assign yl = lut_f[1];

    // register-input selector
    always_comb begin
        if (ctl.zm_r)      rin = cell_z;
        else if (ctl.yl_r) rin = yl;
        else               rin = xl;
    end

    lcell_reg u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .sr            (reg_sr),
        .init_is_reset (oct[IDX_INIT][INIT_BIT]),
        .ce            (reg_ce),
        .d             (rin),
        .q             (q_r)
    );

    assign out_c  = ctl.zm_c  ? rin   : q_r;
    assign out_fb = ctl.zm_fb ? rin   : q_r;
    assign out_xo = ctl.c_xo  ? out_c : xl;
    assign out_yo = ctl.c_yo  ? out_c : yl;
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [3:0]  zhi,
    input logic        reg_ce,
    input logic        reg_sr,
    input logic        out_xo,
    input logic        out_c,
    input logic        out_fb,
    input logic [31:0] octs,
    input logic        q,
    input logic        rin
);
    p_cfg_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && zhi != 4'b0000) |=> $stable(octs));

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ce && !reg_sr) |=> (q == $past(rin)) || reg_sr);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_ce && !reg_sr) |=> $stable(q) || reg_sr);

    p_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sr |-> (q == !octs[27]));

    p_fb_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        octs[2] |-> (out_fb == rin));

    p_xo_centre_r9: assert property (@(posedge clk) disable iff (!rst_n)
        octs[1] |-> (out_xo == out_c));
endmodule

bind lcell_top lcell_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .zhi    (cfg_z[7:4]),
    .reg_ce (reg_ce),
    .reg_sr (reg_sr),
    .out_xo (out_xo),
    .out_c  (out_c),
    .out_fb (out_fb),
    .octs   (oct),
    .q      (q_r),
    .rin    (rin)
);

// File: tb/lcell_top_test.sv
module lcell_top_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_z = 8'h00, cfg_d = 8'h00;
    logic       cell_x = 0, cell_y = 0, cell_w = 0, cell_z = 0;
    logic       reg_ce = 0, reg_sr = 0;
    logic       out_xo, out_yo, out_c, out_fb;

    always #(PERIOD/2) clk = ~clk;

    lcell_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_z(cfg_z), .cfg_d(cfg_d),
        .cell_x(cell_x), .cell_y(cell_y), .cell_w(cell_w), .cell_z(cell_z),
        .reg_ce(reg_ce), .reg_sr(reg_sr),
        .out_xo(out_xo), .out_yo(out_yo), .out_c(out_c), .out_fb(out_fb)
    );

    // reference model state
    logic [7:0] m_ctl = 8'hFF, m_xt = 8'hFF, m_yt = 8'hFF, m_pol = 8'hFF;
    logic       m_q = 1'b0;
    int         checks = 0, errors = 0;
    string      req = "R1";
    bit         done = 0;

    task automatic model(output logic exo, output logic eyo, output logic ec,
                         output logic efb, output logic erin);
        logic third, xlv, ylv;
        int   a;
        third = m_ctl[5] ? (cell_w & cell_z) : (m_ctl[4] ? m_q : cell_w);
        a     = (third ? 4 : 0) + (cell_y ? 2 : 0) + (cell_x ? 1 : 0);
        xlv   = !m_xt[a];
        ylv   = !m_yt[a];
        erin  = m_ctl[7] ? cell_z : (m_ctl[6] ? ylv : xlv);
        ec    = m_ctl[3] ? erin : m_q;
        efb   = m_ctl[2] ? erin : m_q;
        exo   = m_ctl[1] ? ec : xlv;
        eyo   = m_ctl[0] ? ec : ylv;
    endtask

    task automatic check1(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cycle(input logic we, input logic [7:0] zz, input logic [7:0] dd,
                         input logic s, input logic e, input logic [3:0] wzyx);
        logic exo, eyo, ec, efb, erin;
        @(negedge clk);
        cfg_we = we; cfg_z = zz; cfg_d = dd;
        reg_sr = s;  reg_ce = e;
        {cell_w, cell_z, cell_y, cell_x} = wzyx;
        #1;
        if (rst_n && s) m_q = !m_pol[3];
        model(exo, eyo, ec, efb, erin);
        check1("out_xo", out_xo, exo);
        check1("out_yo", out_yo, eyo);
        check1("out_c",  out_c,  ec);
        check1("out_fb", out_fb, efb);
        @(posedge clk);
        if (rst_n) begin
            if (s) m_q = !m_pol[3];
            else if (e) m_q = erin;
            if (we && zz[7:4] == 4'h0) begin
                case (zz[3:0])
                    4'h1: m_ctl = dd;
                    4'h6: m_xt  = dd;
                    4'h7: m_yt  = dd;
                    4'hA: m_pol = dd;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic wr(input logic [7:0] zz, input logic [7:0] dd);
        cycle(1'b1, zz, dd, 1'b0, 1'b0, 4'($urandom));
    endtask

    task automatic rnd(input int n, input bit use_sr, input bit ce_on);
        for (int i = 0; i < n; i++) begin
            logic s;
            s = use_sr ? (($urandom % 4) == 0) : 1'b0;
            cycle(1'b0, 8'h00, 8'h00, s, ce_on ? 1'($urandom) : 1'b0, 4'($urandom));
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

    initial begin
        // R1: reset state, outputs follow cell_z
        req = "R1";
        cycle(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'b0100);
        cycle(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'b1011);
        @(negedge clk); rst_n = 1'b1;
        rnd(6, 0, 1);

        // R2: ignored writes, then a real one
        req = "R2";
        wr(8'h16, 8'h00);
        wr(8'h86, 8'h00);
        cycle(1'b0, 8'h06, 8'h00, 1'b0, 1'b0, 4'b0000);
        rnd(3, 0, 1);
        wr(8'h01, 8'h00);
        rnd(3, 0, 1);

        // R3: inverted tables, full index sweep
        req = "R3";
        wr(8'h06, 8'h69);
        wr(8'h07, 8'h7F);
        for (int i = 0; i < 8; i++)
            cycle(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, {i[2], 1'b0, i[1], i[0]});
        for (int i = 0; i < 8; i++)
            cycle(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, {i[2], 1'b1, i[1], i[0]});

        // R4: third-input selector
        req = "R4";
        wr(8'h01, 8'h20); rnd(16, 0, 1);
        wr(8'h01, 8'h10); rnd(16, 0, 1);
        wr(8'h01, 8'h30); rnd(16, 0, 1);

        // R5: register-input selector observed through the centre output
        req = "R5";
        wr(8'h01, 8'h82); rnd(12, 0, 1);
        wr(8'h01, 8'h42); rnd(12, 0, 1);
        wr(8'h01, 8'hC2); rnd(12, 0, 1);
        wr(8'h01, 8'h02); rnd(12, 0, 1);

        // R6: hold with enable low
        req = "R6";
        rnd(8, 0, 0);
        rnd(8, 0, 1);

        // R7: asynchronous initialise, both polarities
        req = "R7";
        wr(8'h0A, 8'hF7); rnd(16, 1, 1);
        wr(8'h0A, 8'hFF); rnd(16, 1, 1);
        wr(8'h0A, 8'h08); rnd(8, 1, 1);

        // R8: bypass of centre and feedback
        req = "R8";
        wr(8'h01, 8'h0C); rnd(10, 0, 1);
        wr(8'h01, 8'h48); rnd(10, 0, 1);
        wr(8'h01, 8'h14); rnd(10, 0, 1);

        // R9: neighbour output selection
        req = "R9";
        wr(8'h01, 8'h01); rnd(10, 0, 1);
        wr(8'h01, 8'h0B); rnd(10, 0, 1);
        wr(8'h01, 8'h00); rnd(10, 0, 1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end
endmodule